// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Sequencer

This block is the control sequencer for an SRAM whose array has a nonvolatile copy. It decides when the array may be read or written by the host. It copies the array into the nonvolatile cells (a store) when asked, or on power loss if automatic stores are enabled. It copies the cells back (a recall) whenever power returns.

A store is requested by pulling a shared active-low request/busy line low. The block itself pulls the same line low for as long as a store runs. The array data path, the nonvolatile cells and the voltage sensing are outside the block. Store, recall and grace-window durations are parameters counted in clock cycles.

The host strobes `ce_n`/`we_n` (both active low) drive the access enables. A read is `ce_n`=0 with `we_n`=1. A write is `ce_n`=0 with `we_n`=0. Each enable is registered and reflects the strobes sampled at the previous clock edge.

Top module: `nvsram_seq`

## Requirements
- R1: While `rst` is high, `busy_pull`, `recall_busy`, `sram_rd_en` and `sram_wr_en` are 0. After reset the block behaves as after a power return: with `pwr_good` high, a recall starts at the first clock edge.
- R2: Each time `pwr_good` returns high, `recall_busy` is 1 for exactly RECALL_CYC cycles. No SRAM access is enabled during that time, and a store never overlaps a recall.
- R3: In the idle state, `sram_rd_en` is 1 one cycle after a read strobe and `sram_wr_en` is 1 one cycle after a write strobe. Neither enable rises without its strobe.
- R4: When the request line falls and the modified flag is set, `busy_pull` rises SYNC_STAGES+1+DELAY_CYC cycles later and stays 1 for exactly STORE_CYC cycles.
- R5: Reads stay enabled throughout the DELAY_CYC grace window that precedes a store.
- R6: A write already enabled when the request is detected stays enabled through the grace window while its strobe is held. A write strobe that begins after detection is not enabled.
- R7: During a store, and afterwards until the request line has been sampled high through the synchronizer, both enables are 0.
- R8: A request that arrives while the modified flag is clear starts no store and never raises `busy_pull`. Reads stay enabled, and new writes stay blocked until the line returns high.
- R9: The modified flag is set by each enabled write and cleared when a store or a recall completes.
- R10: While `pwr_good` is low, no write is enabled and a request on the line is ignored.
- R11: If `auto_store_en` is 1 and the modified flag is set when `pwr_good` falls, a store of STORE_CYC cycles starts at the next edge. With `auto_store_en` 0, or with the flag clear, no store runs on power loss.
- R12: If a write strobe is held when a store or recall hands control back, writes stay blocked until a falling edge is seen on `ce_n` or `we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply valid |
| auto_store_en | input | 1 | 1: store automatically on power loss |
| hsreq_n | input | 1 | Sample of the shared request/busy line (active low) |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| busy_pull | output | 1 | 1: pull the shared line low (open drain) |
| recall_busy | output | 1 | Recall in progress |
| sram_rd_en | output | 1 | Array read enable |
| sram_wr_en | output | 1 | Array write enable |

## Verification
Two functions can land in the same cycle:
- **Request versus a write in flight.** The hardware request and an ongoing host write meet when the line falls while a write strobe is held. The bench sweeps strobe patterns (none, read, held write, write begun after detection) against both states of the modified flag. For every cycle it checks the enables and `busy_pull` against positions computed from the synchronizer depth and the window lengths.
- **Store completion versus re-arming a write.** These meet when a write is still held at hand-back. The bench checks that the write stays blocked and then resumes only after a fresh `we_n` edge.
- **Power loss versus a pending store.** A power drop with and without the modified flag set, and with automatic stores on and off, checks which of store, blocking and recall wins.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RCL   = 3'd1,
    ST_IDLE  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_STORE = 3'd4,
    ST_HOLD  = 3'd5,
    ST_NOACK = 3'd6
  } nvs_state_e;
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl import nvs_pkg::*; #(
  parameter int DELAY_CYC  = 4,
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic auto_en,
  input  logic req_low,
  input  logic dirty,
  output logic busy_pull,
  output logic recall_busy,
  output logic rd_open,
  output logic wr_open,
  output logic wr_cont,
  output logic arm_lock,
  output logic clr_dirty
);
  localparam int M1   = (DELAY_CYC > STORE_CYC) ? DELAY_CYC : STORE_CYC;
  localparam int MAXC = (M1 > RECALL_CYC) ? M1 : RECALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] D_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] S_LAST = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] R_LAST = CW'(RECALL_CYC - 1);

  nvs_state_e state, nxt;
  logic [CW-1:0] cnt;
  logic rcl_pend;
  logic power_store;

  assign power_store = auto_en && dirty;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (pwr_good) nxt = ST_RCL;
      ST_RCL: begin
        if (!pwr_good)          nxt = ST_OFF;
        else if (cnt == R_LAST) nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (!pwr_good)   nxt = power_store ? ST_STORE : ST_OFF;
        else if (req_low) nxt = dirty ? ST_WAIT : ST_NOACK;
      end
      ST_WAIT: begin
        if (!pwr_good)          nxt = power_store ? ST_STORE : ST_OFF;
        else if (cnt == D_LAST) nxt = ST_STORE;
      end
      ST_STORE: if (cnt == S_LAST) nxt = ST_HOLD;
      ST_HOLD: begin
        if (!req_low) begin
          if (!pwr_good)    nxt = ST_OFF;
          else if (rcl_pend) nxt = ST_RCL;
          else              nxt = ST_IDLE;
        end
      end
      ST_NOACK: begin
        if (!pwr_good)    nxt = ST_OFF;
        else if (!req_low) nxt = ST_IDLE;
      end
      default: nxt = ST_OFF;
    endcase
  end

  assign rd_open   = (state == ST_IDLE) || (state == ST_WAIT) || (state == ST_NOACK);
  assign wr_open   = (state == ST_IDLE);
  assign wr_cont   = (state == ST_WAIT);
  assign arm_lock  = (nxt == ST_IDLE) && ((state == ST_RCL) || (state == ST_HOLD));
  assign clr_dirty = ((state == ST_STORE) && (nxt != ST_STORE)) ||
                     ((state == ST_RCL) && (nxt == ST_IDLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OFF;
      cnt         <= '0;
      rcl_pend    <= 1'b1;
      busy_pull   <= 1'b0;
      recall_busy <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if ((state == ST_WAIT) || (state == ST_STORE) || (state == ST_RCL))
        cnt <= cnt + CW'(1);
      if (!pwr_good)                                  rcl_pend <= 1'b1;
      else if ((state == ST_RCL) && (nxt == ST_IDLE)) rcl_pend <= 1'b0;
      busy_pull   <= (nxt == ST_STORE);
      recall_busy <= (nxt == ST_RCL);
    end
  end
endmodule

// File: rtl/nvs_wr_gate.sv
module nvs_wr_gate (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  input  logic pwr_good,
  input  logic rd_open,
  input  logic wr_open,
  input  logic wr_cont,
  input  logic arm_lock,
  input  logic clr_dirty,
  output logic sram_rd_en,
  output logic sram_wr_en,
  output logic dirty
);
  logic ce_q, we_q, lock, cont;
  logic wr_act, rd_act, fresh, wr_ok;

  assign wr_act = !ce_n && !we_n;
  assign rd_act = !ce_n && we_n;
  assign fresh  = (ce_q && !ce_n) || (we_q && !we_n);
  assign wr_ok  = wr_act && !lock && pwr_good && (wr_open || (wr_cont && cont));

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q       <= 1'b1;
      we_q       <= 1'b1;
      lock       <= 1'b0;
      cont       <= 1'b0;
      dirty      <= 1'b0;
      sram_rd_en <= 1'b0;
      sram_wr_en <= 1'b0;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
      cont <= wr_ok;
      if (arm_lock)   lock <= wr_act && !fresh;
      else if (fresh) lock <= 1'b0;
      if (clr_dirty)  dirty <= 1'b0;
      else if (wr_ok) dirty <= 1'b1;
      sram_rd_en <= rd_act && rd_open;
      sram_wr_en <= wr_ok;
    end
  end
endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq #(
  parameter int DELAY_CYC   = 4,
  parameter int STORE_CYC   = 16,
  parameter int RECALL_CYC  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic auto_store_en,
  input  logic hsreq_n,
  input  logic ce_n,
  input  logic we_n,
  output logic busy_pull,
  output logic recall_busy,
  output logic sram_rd_en,
  output logic sram_wr_en
);
  logic req_s, dirty;
  logic rd_open, wr_open, wr_cont, arm_lock, clr_dirty;

  nvs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(hsreq_n), .q(req_s)
  );

  nvs_ctrl #(
    .DELAY_CYC(DELAY_CYC), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .auto_en(auto_store_en),
    .req_low(!req_s), .dirty(dirty), .busy_pull(busy_pull),
    .recall_busy(recall_busy), .rd_open(rd_open), .wr_open(wr_open),
    .wr_cont(wr_cont), .arm_lock(arm_lock), .clr_dirty(clr_dirty)
  );

  nvs_wr_gate u_gate (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .pwr_good(pwr_good),
    .rd_open(rd_open), .wr_open(wr_open), .wr_cont(wr_cont),
    .arm_lock(arm_lock), .clr_dirty(clr_dirty), .sram_rd_en(sram_rd_en),
    .sram_wr_en(sram_wr_en), .dirty(dirty)
  );
endmodule

// File: rtl/nvsram_seq_chk.sv
module nvsram_seq_chk (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic ce_n,
  input logic we_n,
  input logic busy_pull,
  input logic recall_busy,
  input logic sram_rd_en,
  input logic sram_wr_en,
  input logic dirty
);
  p_store_needs_dirty_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_pull) |-> $past(dirty));

  p_no_write_unpowered_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_good) |-> !sram_wr_en);

  p_quiet_during_store_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_pull && $past(busy_pull)) |-> (!sram_wr_en && !sram_rd_en));

  p_quiet_during_recall_r2: assert property (@(posedge clk) disable iff (rst)
    (recall_busy && $past(recall_busy)) |-> (!sram_wr_en && !sram_rd_en));

  p_store_recall_apart_r2: assert property (@(posedge clk) disable iff (rst)
    !(busy_pull && recall_busy));

  p_write_has_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    sram_wr_en |-> $past(!ce_n && !we_n));

  p_read_has_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    sram_rd_en |-> $past(!ce_n && we_n));
endmodule

bind nvsram_seq nvsram_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .ce_n(ce_n), .we_n(we_n),
  .busy_pull(busy_pull), .recall_busy(recall_busy),
  .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en), .dirty(dirty)
);

// File: tb/test_nvsram_seq.sv
module test_nvsram_seq;
  localparam int D = 3;
  localparam int S = 5;
  localparam int R = 4;
  localparam int LAT = 3 + D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b1;
  logic auto_en = 1'b0;
  logic ext_req_n = 1'b1;
  logic ce_n = 1'b1;
  logic we_n = 1'b1;
  logic line_n;
  logic busy_pull, recall_busy, sram_rd_en, sram_wr_en;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit bdirty = 1'b0;

  always #5 clk = ~clk;

  assign line_n = ext_req_n & ~busy_pull;

  nvsram_seq #(.DELAY_CYC(D), .STORE_CYC(S), .RECALL_CYC(R), .SYNC_STAGES(2)) i_nvsram_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .auto_store_en(auto_en),
    .hsreq_n(line_n), .ce_n(ce_n), .we_n(we_n), .busy_pull(busy_pull),
    .recall_busy(recall_busy), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobes(input bit c, input bit w);
    ce_n = c;
    we_n = w;
  endtask

  task automatic measure_recall();
    int n = 0;
    tick();
    chk("R2 recall starts on power return", recall_busy, 1);
    while (recall_busy) begin
      n++;
      tick();
    end
    chk("R2 recall length", n, R);
    bdirty = 1'b0;
  endtask

  task automatic do_write();
    strobes(1'b0, 1'b0);
    tick();
    tick();
    chk("R3 idle write enabled", sram_wr_en, 1);
    strobes(1'b1, 1'b1);
    tick();
    bdirty = 1'b1;
  endtask

  // mode 0 idle, 1 read held, 2 write held, 3 write begun after detection
  task automatic store_seq(input int mode);
    bit st;
    st = bdirty || (mode == 2);
    case (mode)
      1: strobes(1'b0, 1'b1);
      2: strobes(1'b0, 1'b0);
      default: strobes(1'b1, 1'b1);
    endcase
    tick();
    tick();
    if (mode == 2) chk("R3 write before request", sram_wr_en, 1);
    ext_req_n = 1'b0;
    for (int k = 1; k <= LAT + S + 3; k++) begin
      tick();
      chk(st ? "R4 busy window" : "R8 no busy when clean", busy_pull,
          (st && k >= LAT && k < LAT + S) ? 1 : 0);
      if (mode == 1)
        chk(k <= LAT ? "R5 read in window" : "R7 read gated", sram_rd_en,
            (k <= LAT) ? 1 : (st ? 0 : 1));
      if (mode == 2)
        chk("R6 held write continues then stops", sram_wr_en, (k <= LAT) ? 1 : 0);
      if (mode == 3)
        chk("R6 late write blocked", sram_wr_en, 0);
      if (k == 3 && mode == 3) strobes(1'b0, 1'b0);
    end
    ext_req_n = 1'b1;
    for (int m = 1; m <= 4; m++) begin
      tick();
      chk("R7 busy released", busy_pull, 0);
      if (mode == 1)
        chk("R7 hold until line high", sram_rd_en, st ? ((m >= 4) ? 1 : 0) : 1);
      if (mode == 3)
        chk(st ? "R12 held write locked" : "R8 write resumes after release",
            sram_wr_en, (m == 4 && !st) ? 1 : 0);
      if (mode == 2) chk("R12 held write locked", sram_wr_en, 0);
    end
    if (mode == 2) begin
      we_n = 1'b1;
      tick();
      we_n = 1'b0;
      tick();
      chk("R12 lock until edge registered", sram_wr_en, 0);
      tick();
      chk("R12 write after fresh edge", sram_wr_en, 1);
    end
    if (st) bdirty = 1'b0;
    if (mode == 2 || (mode == 3 && !st)) bdirty = 1'b1;
    strobes(1'b1, 1'b1);
    tick();
    tick();
  endtask

  initial begin
    tick();
    tick();
    chk("R1 busy in reset", busy_pull, 0);
    chk("R1 recall flag in reset", recall_busy, 0);
    chk("R1 read enable in reset", sram_rd_en, 0);
    chk("R1 write enable in reset", sram_wr_en, 0);
    rst = 1'b0;
    measure_recall();

    strobes(1'b0, 1'b1);
    tick();
    tick();
    chk("R3 idle read enabled", sram_rd_en, 1);
    chk("R3 read is not a write", sram_wr_en, 0);
    strobes(1'b1, 1'b1);
    tick();
    tick();
    chk("R3 read drops with strobe", sram_rd_en, 0);

    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 4; m++) begin
        if (d == 1 && !bdirty) do_write();
        if (d == 0 && bdirty) store_seq(0);
        store_seq(m);
      end
    end

    // R9: dirty flag cleared by recall; R10: power low blocks writes and requests
    if (!bdirty) do_write();
    auto_en = 1'b0;
    pwr_good = 1'b0;
    tick();
    strobes(1'b0, 1'b0);
    tick();
    tick();
    chk("R10 write blocked without power", sram_wr_en, 0);
    strobes(1'b1, 1'b1);
    ext_req_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R10 request ignored without power", busy_pull, 0);
    end
    ext_req_n = 1'b1;
    tick();
    tick();
    tick();
    pwr_good = 1'b1;
    measure_recall();
    store_seq(0); // R9: must not store after recall cleared the flag

    // R11: automatic store on power loss
    auto_en = 1'b1;
    do_write();
    pwr_good = 1'b0;
    for (int k = 1; k <= S + 1; k++) begin
      tick();
      chk("R11 auto store window", busy_pull, (k <= S) ? 1 : 0);
    end
    tick();
    tick();
    tick();
    tick();
    pwr_good = 1'b1;
    measure_recall();
    store_seq(0);

    // R11: clean flag means no automatic store
    pwr_good = 1'b0;
    for (int k = 1; k <= S + 1; k++) begin
      tick();
      chk("R11 no auto store when clean", busy_pull, 0);
    end
    pwr_good = 1'b1;
    measure_recall();

    summary();
  end
endmodule